// File: doc/BRIEF.md
# Serial Channel Byte FIFO Pair with Request Thresholds

This block holds bytes for one serial channel in two queues. The receive queue takes bytes from the receive shifter and hands them to software. The transmit queue takes bytes from software and hands them to the transmit shifter. Each queue has an enable, a flush strobe, a fill-level readout and a programmable trigger level. The block raises one receive request and one transmit request toward an interrupt controller.

When a queue is enabled it holds up to `DEPTH` bytes (8 by default). When it is disabled it acts as a single-byte buffer. In threshold mode the receive request follows the number of bytes held and the transmit request follows the number of free entries. In transparent mode the receive request means "at least one byte waiting". The transmit request is a one-cycle pulse after each stored byte that leaves room for another.

Software reads and writes through valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. A source that sees valid without ready must hold its data. The queue never drops a presented byte on those two interfaces. The receive shifter has no back-pressure: it pushes with a valid strobe, and a byte pushed into a full receive queue is lost. The loss is reported on an overrun output.

Top module: `sio_fifo_pair`

## Requirements
- R1: After reset both fill levels read 0, `rx_req` is low, `rx_overrun` is low, and both `*_valid` outputs toward consumers are low.
- R2: With a queue enabled, bytes leave in the order they were accepted. The fill level equals accepted bytes minus removed bytes and reaches at most `DEPTH`.
- R3: With a queue disabled its capacity is one byte. When it holds a byte, `tx_wr_ready` is low (transmit) or a further push is refused (receive).
- R4: A one-cycle flush strobe makes that queue's fill level read 0 and its consumer `valid` low on the next cycle. A push or pop in the same cycle as the flush has no effect.
- R5: A receive push while the receive queue is at capacity (and no flush) drops the byte and leaves the queue contents unchanged. `rx_overrun` is high for exactly the following cycle.
- R6: In receive threshold mode (enabled, transparent off), `rx_req` is high while the fill level is at least the effective trigger. The effective trigger is 1 for a trigger value of 0, `DEPTH` for values above `DEPTH`, and the value itself otherwise.
- R7: In receive transparent mode (enabled), `rx_req` is high while the receive fill level is 1 or more.
- R8: In transmit threshold mode (enabled, transparent off), `tx_req` is high while `DEPTH` minus the transmit fill level is at least the effective trigger, which is clamped as in R6.
- R9: In transmit transparent mode (enabled), `tx_req` is high for the one cycle after an accepted write that leaves the queue not full, and low otherwise.
- R10: With a queue disabled, `rx_req` is high while the receive buffer holds its byte, and `tx_req` is high while the transmit buffer is empty.
- R11: `*_valid` toward a consumer is high exactly when the fill level is nonzero. While valid is high and ready is low, the presented byte stays unchanged. `tx_wr_ready` is low whenever the transmit queue is at capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_fifo_en | input | 1 | Receive queue enable (0: single-byte buffer) |
| rx_flush | input | 1 | One-cycle strobe that empties the receive queue |
| rx_transparent | input | 1 | Receive request on any available byte |
| rx_trigger | input | LW (4) | Receive trigger level |
| rx_sh_valid | input | 1 | Byte strobe from the receive shifter |
| rx_sh_data | input | DW (8) | Byte from the receive shifter |
| rx_rd_valid | output | 1 | Receive byte available to software |
| rx_rd_ready | input | 1 | Software takes the receive byte |
| rx_rd_data | output | DW (8) | Oldest receive byte |
| rx_level | output | LW (4) | Receive fill level |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive byte |
| rx_req | output | 1 | Receive request |
| tx_fifo_en | input | 1 | Transmit queue enable (0: single-byte buffer) |
| tx_flush | input | 1 | One-cycle strobe that empties the transmit queue |
| tx_transparent | input | 1 | Per-byte transmit request pulses |
| tx_trigger | input | LW (4) | Transmit trigger level |
| tx_wr_valid | input | 1 | Software offers a transmit byte |
| tx_wr_ready | output | 1 | Transmit queue can accept a byte |
| tx_wr_data | input | DW (8) | Transmit byte from software |
| tx_sh_valid | output | 1 | Transmit byte available to the shifter |
| tx_sh_ready | input | 1 | Shifter takes the transmit byte |
| tx_sh_data | output | DW (8) | Oldest transmit byte |
| tx_level | output | LW (4) | Transmit fill level |
| tx_req | output | 1 | Transmit request |

## Verification
The properties assume that each flush input is a single-cycle strobe, as a self-clearing control bit would produce. They also assume that trigger, enable and transparent controls change only between transfers. They do not assume that software honours ready: a write offered while full is simply not taken. The stimulus drives every input on the falling clock edge and raises flush for one cycle at a time. It changes mode controls only while the affected queue is idle, so the hold and overrun properties apply to every cycle of the run.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE      = 2'd0,
    MODE_THRESHOLD   = 2'd1,
    MODE_TRANSPARENT = 2'd2
  } req_mode_e;

  function automatic req_mode_e pick_mode(input logic en, input logic transp);
    if (!en)         return MODE_SINGLE;
    else if (transp) return MODE_TRANSPARENT;
    else             return MODE_THRESHOLD;
  endfunction

  // Clamp a raw trigger to the range 1..depth.
  function automatic int unsigned clamp_trigger(input int unsigned raw,
                                                input int unsigned depth);
    if (raw == 0)     return 1;
    if (raw > depth)  return depth;
    return raw;
  endfunction

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [LW-1:0] level
);

  localparam logic [LW-1:0] CAP_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] CAP_ONE  = LW'(1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic [LW-1:0] cap;
  logic          push_fire, pop_fire;

  assign cap       = en ? CAP_FULL : CAP_ONE;
  assign in_ready  = !flush && (count < cap);
  assign out_valid = (count != '0);
  assign push_fire = in_valid && in_ready;
  assign pop_fire  = out_valid && out_ready && !flush;
  assign out_data  = store[rd_ptr];
  assign level     = count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_fire) store[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= bump(wr_ptr);
      if (pop_fire)  rd_ptr <= bump(rd_ptr);
      unique case ({push_fire, pop_fire})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sio_rx_req.sv
module sio_rx_req
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          en,
  input  logic          transparent,
  input  logic [LW-1:0] trigger,
  input  logic [LW-1:0] level,
  output logic          req
);

  logic [LW-1:0] trig_eff;
  req_mode_e     mode;

  assign trig_eff = LW'(clamp_trigger(int'(trigger), DEPTH));
  assign mode     = pick_mode(en, transparent);

  always_comb begin
    unique case (mode)
      MODE_SINGLE:      req = (level != '0);
      MODE_TRANSPARENT: req = (level != '0);
      default:          req = (level >= trig_eff);
    endcase
  end

endmodule

// File: rtl/sio_tx_req.sv
module sio_tx_req
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          transparent,
  input  logic [LW-1:0] trigger,
  input  logic [LW-1:0] level,
  input  logic          push_fire,
  input  logic          pop_fire,
  output logic          req
);

  localparam logic [LW-1:0] DEPTH_L   = LW'(DEPTH);
  localparam logic [LW-1:0] NEAR_FULL = LW'(DEPTH - 1);

  logic [LW-1:0] trig_eff;
  logic [LW-1:0] free_slots;
  logic          stored_pulse;
  logic          leaves_room;
  req_mode_e     mode;

  assign trig_eff    = LW'(clamp_trigger(int'(trigger), DEPTH));
  assign free_slots  = DEPTH_L - level;
  assign mode        = pick_mode(en, transparent);
  // A write alone at DEPTH-1 fills the queue; a write paired with a pop cannot.
  assign leaves_room = !(level == NEAR_FULL && !pop_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored_pulse <= 1'b0;
    else        stored_pulse <= push_fire && leaves_room;
  end

  always_comb begin
    unique case (mode)
      MODE_SINGLE:      req = (level == '0);
      MODE_TRANSPARENT: req = stored_pulse;
      default:          req = (free_slots >= trig_eff);
    endcase
  end

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_fifo_en,
  input  logic          rx_flush,
  input  logic          rx_transparent,
  input  logic [LW-1:0] rx_trigger,
  input  logic          rx_sh_valid,
  input  logic [DW-1:0] rx_sh_data,
  output logic          rx_rd_valid,
  input  logic          rx_rd_ready,
  output logic [DW-1:0] rx_rd_data,
  output logic [LW-1:0] rx_level,
  output logic          rx_overrun,
  output logic          rx_req,
  input  logic          tx_fifo_en,
  input  logic          tx_flush,
  input  logic          tx_transparent,
  input  logic [LW-1:0] tx_trigger,
  input  logic          tx_wr_valid,
  output logic          tx_wr_ready,
  input  logic [DW-1:0] tx_wr_data,
  output logic          tx_sh_valid,
  input  logic          tx_sh_ready,
  output logic [DW-1:0] tx_sh_data,
  output logic [LW-1:0] tx_level,
  output logic          tx_req
);

  logic rx_room;
  logic rx_drop;
  logic tx_push_fire, tx_pop_fire;

  // Receive path
  sio_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_fifo_en),
    .flush     (rx_flush),
    .in_valid  (rx_sh_valid),
    .in_ready  (rx_room),
    .in_data   (rx_sh_data),
    .out_valid (rx_rd_valid),
    .out_ready (rx_rd_ready),
    .out_data  (rx_rd_data),
    .level     (rx_level)
  );

  assign rx_drop = rx_sh_valid && !rx_flush && !rx_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_overrun <= 1'b0;
    else        rx_overrun <= rx_drop;
  end

  sio_rx_req #(.DEPTH(DEPTH)) u_rx_req (
    .en          (rx_fifo_en),
    .transparent (rx_transparent),
    .trigger     (rx_trigger),
    .level       (rx_level),
    .req         (rx_req)
  );

  // Transmit path
  sio_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_fifo_en),
    .flush     (tx_flush),
    .in_valid  (tx_wr_valid),
    .in_ready  (tx_wr_ready),
    .in_data   (tx_wr_data),
    .out_valid (tx_sh_valid),
    .out_ready (tx_sh_ready),
    .out_data  (tx_sh_data),
    .level     (tx_level)
  );

  assign tx_push_fire = tx_wr_valid && tx_wr_ready;
  assign tx_pop_fire  = tx_sh_valid && tx_sh_ready && !tx_flush;

  sio_tx_req #(.DEPTH(DEPTH)) u_tx_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (tx_fifo_en),
    .transparent (tx_transparent),
    .trigger     (tx_trigger),
    .level       (tx_level),
    .push_fire   (tx_push_fire),
    .pop_fire    (tx_pop_fire),
    .req         (tx_req)
  );

endmodule

// File: rtl/sio_fifo_pair_chk.sv
module sio_fifo_pair_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_fifo_en,
  input logic          rx_flush,
  input logic          rx_transparent,
  input logic [LW-1:0] rx_trigger,
  input logic          rx_sh_valid,
  input logic [DW-1:0] rx_sh_data,
  input logic          rx_rd_valid,
  input logic          rx_rd_ready,
  input logic [DW-1:0] rx_rd_data,
  input logic [LW-1:0] rx_level,
  input logic          rx_overrun,
  input logic          rx_req,
  input logic          tx_fifo_en,
  input logic          tx_flush,
  input logic          tx_transparent,
  input logic [LW-1:0] tx_trigger,
  input logic          tx_wr_valid,
  input logic          tx_wr_ready,
  input logic [DW-1:0] tx_wr_data,
  input logic          tx_sh_valid,
  input logic          tx_sh_ready,
  input logic [DW-1:0] tx_sh_data,
  input logic [LW-1:0] tx_level,
  input logic          tx_req
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= DEPTH_L);  // R2

  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_level == '0) && !rx_rd_valid);  // R4

  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_level == '0) && !tx_sh_valid);  // R4

  AST_RX_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sh_valid && !rx_flush && rx_fifo_en && rx_level == DEPTH_L) |=> rx_overrun);  // R5

  AST_RX_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_sh_valid && !rx_flush));  // R5

  AST_TX_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fifo_en && tx_level != '0) |-> !tx_wr_ready);  // R3

  AST_TX_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == DEPTH_L) |-> !tx_wr_ready);  // R11

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sh_valid && !tx_sh_ready && !tx_flush) |=> tx_sh_valid && $stable(tx_sh_data));  // R11

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_valid && !rx_rd_ready && !rx_flush) |=> rx_rd_valid && $stable(rx_rd_data));  // R11

  AST_TX_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_fifo_en && tx_transparent && $past(tx_fifo_en && tx_transparent))
      |-> $past(tx_wr_valid && tx_wr_ready));  // R9

endmodule

bind sio_fifo_pair sio_fifo_pair_chk #(.DEPTH(DEPTH), .DW(DW)) u_sio_fifo_pair_chk (.*);

// File: tb/test_sio_fifo_pair.sv
module test_sio_fifo_pair;

  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_fifo_en = 1'b1, rx_flush = 1'b0, rx_transparent = 1'b0;
  logic [LW-1:0] rx_trigger = LW'(3);
  logic          rx_sh_valid = 1'b0;
  logic [DW-1:0] rx_sh_data = '0;
  logic          rx_rd_valid, rx_rd_ready = 1'b0;
  logic [DW-1:0] rx_rd_data;
  logic [LW-1:0] rx_level;
  logic          rx_overrun, rx_req;
  logic          tx_fifo_en = 1'b1, tx_flush = 1'b0, tx_transparent = 1'b0;
  logic [LW-1:0] tx_trigger = LW'(4);
  logic          tx_wr_valid = 1'b0, tx_wr_ready;
  logic [DW-1:0] tx_wr_data = '0;
  logic          tx_sh_valid, tx_sh_ready = 1'b0;
  logic [DW-1:0] tx_sh_data;
  logic [LW-1:0] tx_level;
  logic          tx_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sio_fifo_pair #(.DEPTH(DEPTH), .DW(DW)) i_sio_fifo_pair (.*);

  // Layout: [22] push, [21:14] push byte, [13] pop, [12:5] byte expected at pop,
  //         [4:1] receive level after the edge, [0] receive request after the edge
  localparam int NVEC = 10;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 8'hA1, 1'b0, 8'h00, 4'd1, 1'b0},
    {1'b1, 8'hA2, 1'b0, 8'h00, 4'd2, 1'b0},
    {1'b1, 8'hA3, 1'b0, 8'h00, 4'd3, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'hA1, 4'd2, 1'b0},
    {1'b1, 8'hA4, 1'b1, 8'hA2, 4'd2, 1'b0},
    {1'b1, 8'hA5, 1'b0, 8'h00, 4'd3, 1'b1},
    {1'b1, 8'hA6, 1'b0, 8'h00, 4'd4, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'hA3, 4'd3, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'hA4, 4'd2, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'hA5, 4'd1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flush_both();
    rx_flush = 1'b1; tx_flush = 1'b1;
    step();
    rx_flush = 1'b0; tx_flush = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rx_level == 0, "R1 rx_level", rx_level, 0);
    chk(tx_level == 0, "R1 tx_level", tx_level, 0);
    chk(!rx_req && !rx_overrun, "R1 rx_req/overrun", {rx_req, rx_overrun}, 0);
    chk(!rx_rd_valid && !tx_sh_valid, "R1 valids", {rx_rd_valid, tx_sh_valid}, 0);
    rst_n = 1'b1;
    step();

    // Vector table: receive queue, threshold mode, trigger 3 (R2, R6)
    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = VEC[i];
      rx_sh_valid = v[22];
      rx_sh_data  = v[21:14];
      rx_rd_ready = v[13];
      if (v[13]) chk(rx_rd_data == v[12:5], "R2 order", rx_rd_data, v[12:5]);
      step();
      rx_sh_valid = 1'b0;
      rx_rd_ready = 1'b0;
      chk(rx_level == v[4:1], "R2 level", rx_level, v[4:1]);
      chk(rx_req == v[0], "R6 rx_req", rx_req, v[0]);
    end

    // R4: flush together with a push leaves the queue empty
    rx_flush = 1'b1; rx_sh_valid = 1'b1; rx_sh_data = 8'hEE;
    step();
    rx_flush = 1'b0; rx_sh_valid = 1'b0;
    chk(rx_level == 0, "R4 rx flush level", rx_level, 0);
    chk(!rx_rd_valid, "R4 rx valid after flush", rx_rd_valid, 0);

    // R5 and R2: fill to 8, overrun on the ninth push, then drain in order
    for (int i = 0; i < DEPTH; i++) begin
      rx_sh_valid = 1'b1; rx_sh_data = DW'(8'h10 + i);
      step();
    end
    chk(rx_level == DEPTH, "R2 full level", rx_level, DEPTH);
    chk(!rx_overrun, "R5 no overrun before full push", rx_overrun, 0);
    rx_sh_data = 8'h99;
    step();
    rx_sh_valid = 1'b0;
    chk(rx_overrun, "R5 overrun pulse", rx_overrun, 1);
    chk(rx_level == DEPTH, "R5 level unchanged", rx_level, DEPTH);
    step();
    chk(!rx_overrun, "R5 overrun one cycle", rx_overrun, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rx_rd_data == DW'(8'h10 + i), "R2 drain order", rx_rd_data, 8'h10 + i);
      rx_rd_ready = 1'b1;
      step();
    end
    rx_rd_ready = 1'b0;
    chk(rx_level == 0, "R2 drained", rx_level, 0);

    // R6: trigger clamping
    rx_trigger = '0;
    rx_sh_valid = 1'b1; rx_sh_data = 8'h31;
    step();
    rx_sh_valid = 1'b0;
    chk(rx_req, "R6 trigger 0 acts as 1", rx_req, 1);
    rx_trigger = LW'(15);
    step();
    chk(!rx_req, "R6 trigger above depth", rx_req, 0);

    // R7: transparent mode, trigger 5
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    rx_transparent = 1'b1; rx_trigger = LW'(5);
    step();
    chk(!rx_req, "R7 empty no request", rx_req, 0);
    rx_sh_valid = 1'b1; rx_sh_data = 8'h42;
    step();
    rx_sh_valid = 1'b0;
    chk(rx_req, "R7 one byte requests", rx_req, 1);
    rx_transparent = 1'b0;

    // R3, R10, R5: receive disabled is a single-byte buffer
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    rx_fifo_en = 1'b0;
    rx_sh_valid = 1'b1; rx_sh_data = 8'h55;
    step();
    chk(rx_level == 1, "R3 rx single level", rx_level, 1);
    chk(rx_req, "R10 rx request when held", rx_req, 1);
    rx_sh_data = 8'h66;
    step();
    rx_sh_valid = 1'b0;
    chk(rx_overrun, "R5 single buffer overrun", rx_overrun, 1);
    chk(rx_level == 1 && rx_rd_data == 8'h55, "R3 first byte kept", rx_rd_data, 8'h55);
    rx_fifo_en = 1'b1;
    rx_flush = 1'b1; step(); rx_flush = 1'b0;

    // R8, R11: transmit threshold mode, trigger 4
    tx_trigger = LW'(4);
    step();
    chk(tx_req, "R8 empty has room", tx_req, 1);
    for (int i = 0; i < 5; i++) begin
      tx_wr_valid = 1'b1; tx_wr_data = DW'(8'h70 + i);
      step();
    end
    tx_wr_valid = 1'b0;
    chk(tx_level == 5, "R2 tx level", tx_level, 5);
    chk(!tx_req, "R8 three free below trigger", tx_req, 0);
    chk(tx_sh_valid && tx_sh_data == 8'h70, "R11 tx head", tx_sh_data, 8'h70);
    step();
    chk(tx_sh_data == 8'h70, "R11 tx head held", tx_sh_data, 8'h70);
    tx_sh_ready = 1'b1;
    step();
    tx_sh_ready = 1'b0;
    chk(tx_req, "R8 four free meets trigger", tx_req, 1);
    chk(tx_sh_data == 8'h71, "R2 tx order", tx_sh_data, 8'h71);
    tx_flush = 1'b1; tx_sh_ready = 1'b1;
    step();
    tx_flush = 1'b0; tx_sh_ready = 1'b0;
    chk(tx_level == 0 && !tx_sh_valid, "R4 tx flush", tx_level, 0);

    // R9, R11: transparent transmit pulses
    tx_transparent = 1'b1;
    step();
    chk(!tx_req, "R9 idle low", tx_req, 0);
    tx_wr_valid = 1'b1; tx_wr_data = 8'h80;
    step();
    tx_wr_valid = 1'b0;
    chk(tx_req, "R9 pulse after write", tx_req, 1);
    step();
    chk(!tx_req, "R9 pulse ends", tx_req, 0);
    for (int i = 1; i < DEPTH; i++) begin
      tx_wr_valid = 1'b1; tx_wr_data = DW'(8'h80 + i);
      step();
      if (i < DEPTH - 1) chk(tx_req, "R9 pulse not full", tx_req, 1);
    end
    tx_wr_valid = 1'b0;
    chk(!tx_req, "R9 no pulse when full", tx_req, 0);
    chk(tx_level == DEPTH && !tx_wr_ready, "R11 full blocks writes", tx_wr_ready, 0);
    tx_transparent = 1'b0;
    flush_both();

    // R3, R10: transmit disabled is a single-byte buffer
    tx_fifo_en = 1'b0;
    step();
    chk(tx_req, "R10 tx empty requests", tx_req, 1);
    tx_wr_valid = 1'b1; tx_wr_data = 8'h91;
    step();
    tx_wr_valid = 1'b0;
    chk(tx_level == 1 && !tx_wr_ready, "R3 tx single full", tx_wr_ready, 0);
    chk(!tx_req, "R10 tx held no request", tx_req, 0);
    tx_sh_ready = 1'b1;
    step();
    tx_sh_ready = 1'b0;
    chk(tx_level == 0 && tx_req, "R10 tx request after pop", tx_req, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule